// File: doc/BRIEF.md
# Shared Processor/Logic Port Pin Controller

This block controls one 8-pin general-purpose port whose pins are shared between a processor register interface and an on-chip programmable logic array. A small register file sits on a simple synchronous bus. It holds an output-data register, a direction register and a packed per-pin mode field. A synchronized copy of the pad levels can be read back through the same bus. For each pin the block works out a tri-state enable and a drive value, and it always passes the raw pad levels on to the logic array's input bus.

Every pin is in one of three modes. In processor mode the pin follows the registers. In logic-input mode the pin still follows the registers, and the array only listens to it. In logic-output mode the array supplies the drive value, and the pin's buffer is enabled by either the direction bit or the array's own enable for that pin. A parameter sets the mode field's reset value. A pin can therefore come out of reset already owned by the array and drive at once if the array enables it.

Top module: `shared_port_ctrl`

## Requirements
- R1: After reset the output-data and direction registers read 00h and the mode register reads the `RST_MODE` parameter. Every pin whose reset mode is not logic-output has its enable low, whatever `lgc_oe` is.
- R2: In processor mode (mode code 00), `pin_oe[i]` equals direction bit i and `pin_out[i]` equals output-data bit i. `lgc_oe[i]` and `lgc_out[i]` have no effect.
- R3: In logic-output mode (mode code 10), `pin_oe[i]` is direction bit i OR `lgc_oe[i]` and `pin_out[i]` equals `lgc_out[i]`. Writes to the output-data register do not change the pin.
- R4: In logic-input mode (mode code 01), `pin_oe[i]` equals direction bit i and `pin_out[i]` equals output-data bit i. `lgc_oe[i]` has no effect.
- R5: A read at offset 0 returns the pad levels through a two-flop synchronizer: after a pad change, the read returns the old value for one clock edge and the new value from the second edge on, in any mode.
- R6: `lgc_in_bus` equals `pin_in` at all times, in every mode.
- R7: The register map is offset 0 pad levels (read only), offset 1 output data, offset 2 direction, offset 3 mode of pins 0-3 and offset 4 mode of pins 4-7. Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Writes to offsets 0, 5, 6 and 7 change nothing, and reads there return 00h, except offset 0.
- R8: Pin i's mode code sits at bits [2(i mod 4)+1 : 2(i mod 4)] of its mode byte. Code 11 is reserved and behaves as processor mode.
- R9: A pin whose `RST_MODE` code is logic-output drives `lgc_out` while in reset and just after it whenever its `lgc_oe` is high, even though its direction bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Pad levels seen at the pins |
| pin_out | output | 8 | Drive value per pin |
| pin_oe | output | 8 | Tri-state enable per pin, high drives |
| lgc_out | input | 8 | Drive values from the logic array |
| lgc_oe | input | 8 | Output enables from the logic array |
| lgc_in_bus | output | 8 | Pad levels forwarded to the logic array |

## Verification
Several checks run on every cycle. One confirms that a logic-output pin is enabled whenever the array enables it. One confirms that processor and logic-input pins never drive with a clear direction bit and, when driving, carry the output-data bit. One confirms that the synchronizer delivers exactly the pad level of two cycles before, and one that writes to the read-only offset leave the registers alone. Other behaviours can only be shown by the bench's scenarios: the packed mode byte layout, the reserved code, the readback of every offset, the register writes that a logic-output pin ignores, and a pin driving straight out of reset.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

    localparam int PINS    = 8;
    localparam int ADDR_W  = 3;
    localparam int MODE_W  = 2 * PINS;
    localparam int PER_BYTE = 4;

    typedef enum logic [1:0] {
        PM_CPU  = 2'b00,
        PM_LIN  = 2'b01,
        PM_LOUT = 2'b10,
        PM_RSVD = 2'b11
    } pin_mode_e;

    localparam logic [ADDR_W-1:0] OFS_DIN     = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DOUT    = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_MODE_LO = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MODE_HI = 3'd4;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drv_t;

    function automatic pin_mode_e mode_of(input logic [MODE_W-1:0] m, input int idx);
        return pin_mode_e'(m[2*idx +: 2]);
    endfunction

endpackage

// File: rtl/port_regs.sv
module port_regs
    import gpio_share_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_MODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic [PINS-1:0]   din_sync,
    output logic [PINS-1:0]   bus_rdata,
    output logic [PINS-1:0]   dout_q,
    output logic [PINS-1:0]   dir_q,
    output logic [MODE_W-1:0] mode_q
);

    localparam int HALF = MODE_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
            mode_q <= RST_MODE;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DOUT:    dout_q <= bus_wdata;
                OFS_DIR:     dir_q  <= bus_wdata;
                OFS_MODE_LO: mode_q[HALF-1:0]      <= bus_wdata;
                OFS_MODE_HI: mode_q[MODE_W-1:HALF] <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DIN:     bus_rdata = din_sync;
            OFS_DOUT:    bus_rdata = dout_q;
            OFS_DIR:     bus_rdata = dir_q;
            OFS_MODE_LO: bus_rdata = mode_q[HALF-1:0];
            OFS_MODE_HI: bus_rdata = mode_q[MODE_W-1:HALF];
            default:     bus_rdata = '0;
        endcase
    end

    AST_RO_DIN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DIN) |=> ($stable(dout_q) && $stable(dir_q) && $stable(mode_q))); // R7

endmodule

// File: rtl/pad_sync.sv
module pad_sync
    import gpio_share_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_sync_q
);

    logic [PINS-1:0] stage1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q   <= '0;
            pad_sync_q <= '0;
        end else begin
            stage1_q   <= pad_in;
            pad_sync_q <= stage1_q;
        end
    end

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_SYNC_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        (warm_q >= 2'd2) |-> (pad_sync_q == $past(pad_in, 2))); // R5

endmodule

// File: rtl/pin_cell.sv
module pin_cell
    import gpio_share_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_code,
    input  logic       dir_bit,
    input  logic       dout_bit,
    input  logic       lgc_val,
    input  logic       lgc_en,
    output pad_drv_t   drv
);

    pin_mode_e mode;
    assign mode = pin_mode_e'(mode_code);

    always_comb begin
        case (mode)
            PM_LOUT: begin
                drv.oe  = dir_bit | lgc_en;
                drv.val = lgc_val;
            end
            PM_LIN: begin
                drv.oe  = dir_bit;
                drv.val = dout_bit;
            end
            default: begin
                drv.oe  = dir_bit;
                drv.val = dout_bit;
            end
        endcase
    end

    AST_LOUT_ARRAY_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_LOUT && lgc_en) |-> (drv.oe && drv.val == lgc_val)); // R3

    AST_CPU_NO_ARRAY_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ((mode == PM_CPU || mode == PM_RSVD) && !dir_bit) |-> !drv.oe); // R2

    AST_LIN_REG_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_LIN) |-> (drv.oe == dir_bit && (!drv.oe || drv.val == dout_bit))); // R4

endmodule

// File: rtl/shared_port_ctrl.sv
module shared_port_ctrl
    import gpio_share_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_MODE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    input  logic [PINS-1:0]   lgc_out,
    input  logic [PINS-1:0]   lgc_oe,
    output logic [PINS-1:0]   lgc_in_bus
);

    logic [PINS-1:0]   din_sync;
    logic [PINS-1:0]   dout_q;
    logic [PINS-1:0]   dir_q;
    logic [MODE_W-1:0] mode_q;

    pad_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .pad_in     (pin_in),
        .pad_sync_q (din_sync)
    );

    port_regs #(.RST_MODE(RST_MODE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .din_sync  (din_sync),
        .bus_rdata (bus_rdata),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .mode_q    (mode_q)
    );

    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            pad_drv_t drv;
            pin_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .mode_code (mode_q[2*i +: 2]),
                .dir_bit   (dir_q[i]),
                .dout_bit  (dout_q[i]),
                .lgc_val   (lgc_out[i]),
                .lgc_en    (lgc_oe[i]),
                .drv       (drv)
            );
            assign pin_oe[i]  = drv.oe;
            assign pin_out[i] = drv.val;
        end
    endgenerate

    assign lgc_in_bus = pin_in;

endmodule

// File: tb/sim_shared_port_ctrl.sv
`timescale 1ns/1ps
module sim_shared_port_ctrl;

    localparam logic [15:0] RMODE = 16'h8000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic [7:0] lgc_out = 8'h80;
    logic [7:0] lgc_oe = 8'hFF;
    logic [7:0] lgc_in_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0]  m_dout = '0, m_dir = '0;
    logic [15:0] m_mode = RMODE;

    always #2.5 clk = ~clk;

    shared_port_ctrl #(.RST_MODE(RMODE)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .lgc_out(lgc_out),
        .lgc_oe(lgc_oe), .lgc_in_bus(lgc_in_bus)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (m_mode[2*i +: 2] == 2'b10) ? (m_dir[i] | lgc_oe[i]) : m_dir[i];
        return r;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = (m_mode[2*i +: 2] == 2'b10) ? lgc_out[i] : m_dout[i];
        return r;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            3'd1: m_dout = d;
            3'd2: m_dir  = d;
            3'd3: m_mode[7:0]  = d;
            3'd4: m_mode[15:8] = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_pins(input string req);
        #1;
        chk({req, " oe"},  pin_oe,  exp_oe());
        chk({req, " out"}, pin_out, exp_out());
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk_pins("R1/R9 in reset");
        @(negedge clk); rst = 1'b0;
        chk_pins("R9 after reset");
        rd(3'd1, d); chk("R1 dout", d, 8'h00);
        rd(3'd2, d); chk("R1 dir", d, 8'h00);
        rd(3'd3, d); chk("R1 mode lo", d, 8'h00);
        rd(3'd4, d); chk("R1 mode hi", d, 8'h80);
    endtask

    task automatic t_cpu();
        wr(3'd4, 8'h00);
        lgc_oe = 8'hFF; lgc_out = 8'h00;
        wr(3'd1, 8'h3C);
        wr(3'd2, 8'h0F);
        chk_pins("R2 cpu");
        chk("R2 oe value", pin_oe, 8'h0F);
        chk("R2 out value", pin_out, 8'h3C);
        lgc_oe = 8'h00; lgc_out = 8'hFF;
        chk_pins("R2 lgc ignored");
    endtask

    task automatic t_lout();
        wr(3'd3, 8'hAA);
        wr(3'd4, 8'hAA);
        lgc_out = 8'h96; lgc_oe = 8'hF0;
        chk_pins("R3 lout");
        chk("R3 oe value", pin_oe, 8'hFF);
        chk("R3 out value", pin_out, 8'h96);
        wr(3'd1, 8'hFF);
        chk("R3 dout ignored", pin_out, 8'h96);
        wr(3'd2, 8'h00);
        chk("R3 array enable only", pin_oe, 8'hF0);
    endtask

    task automatic t_lin();
        wr(3'd3, 8'h55);
        wr(3'd4, 8'h55);
        lgc_oe = 8'hFF; lgc_out = 8'h00;
        wr(3'd1, 8'hC3);
        wr(3'd2, 8'h81);
        chk_pins("R4 lin");
        chk("R4 oe value", pin_oe, 8'h81);
        chk("R4 out value", pin_out, 8'hC3);
    endtask

    task automatic t_din();
        logic [7:0] d;
        @(negedge clk); pin_in = 8'hA5;
        rd(3'd0, d); chk("R5 before edge", d, 8'h00);
        #1; chk("R6 forward", lgc_in_bus, 8'hA5);
        @(negedge clk);
        rd(3'd0, d); chk("R5 one edge", d, 8'h00);
        @(negedge clk);
        rd(3'd0, d); chk("R5 two edges", d, 8'hA5);
        wr(3'd3, 8'hAA);
        pin_in = 8'h3E;
        #1; chk("R6 forward lout", lgc_in_bus, 8'h3E);
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); chk("R5 lout mode", d, 8'h3E);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'h1B); wr(3'd4, 8'hE4);
        rd(3'd1, d); chk("R7 dout rb", d, 8'h12);
        rd(3'd2, d); chk("R7 dir rb", d, 8'h34);
        rd(3'd3, d); chk("R7 mode lo rb", d, 8'h1B);
        rd(3'd4, d); chk("R7 mode hi rb", d, 8'hE4);
        wr(3'd0, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd1, d); chk("R7 ignored dout", d, 8'h12);
        rd(3'd2, d); chk("R7 ignored dir", d, 8'h34);
        rd(3'd3, d); chk("R7 ignored mode lo", d, 8'h1B);
        rd(3'd4, d); chk("R7 ignored mode hi", d, 8'hE4);
        for (int a = 5; a < 8; a++) begin
            rd(a[2:0], d); chk("R7 unused read", d, 8'h00);
        end
    endtask

    task automatic t_layout();
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h00);
        lgc_out = 8'hFF; lgc_oe = 8'hFF;
        wr(3'd3, 8'b11_10_01_00);
        wr(3'd4, 8'b00_00_10_00);
        chk_pins("R8 layout");
        chk("R8 oe pins", pin_oe, 8'h24);
        chk("R8 out pins", pin_out, 8'h24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_cpu();
        t_lout();
        t_lin();
        t_din();
        t_map();
        t_layout();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule